// File: doc/BRIEF.md
# Core Timer Prescaled Clock Generator

This block produces the advance for a free-running 64-bit core timer. Two tick enables arrive in the block's clock domain: a crystal-rate tick and an alternate bus-clock tick. One control bit picks which of them drives the timer. Every selected tick adds a programmable prescaler value to a phase accumulator. When the sum reaches the unity value, the timer takes one step. The step size is 1 or 2, chosen by a second control bit.

Software programs the block through a plain 32-bit register bus with two registers: a control word and a prescaler word. The prescaler is a fixed-point fraction in which 0x80000000 means one timer step per source tick. Smaller values slow the timer in proportion. Larger values are clamped to that same one-to-one rate. The block outputs the running count and a one-cycle pulse on every cycle in which the count moved. Compare logic and interrupt generation are left to blocks downstream.

Top module: `core_timer_gen`

## Requirements
- R1: After reset the control word reads 0, the prescaler reads 0x80000000, the count is 0, and `step_pulse` is low.
- R2: A write at offset 0x000 updates the control word and a write at offset 0x008 updates the prescaler. Each register reads back the full 32-bit value last written to it. A read at any other offset returns 0, and a write at any other offset changes neither register.
- R3: Control bit 8 picks the timer source: 0 selects `xtal_tick` and 1 selects `alt_tick`. Ticks on the source that is not selected have no effect on the count or on the phase.
- R4: Control bit 9 picks the step size: 0 adds 1 per step and 1 adds 2 per step. The value used is the bit as it stood before the clock edge at which the step is taken.
- R5: On each selected tick, the prescaler value P is added to a 31-bit phase. If the sum is at least 2^31, one step is taken and the phase keeps the sum minus 2^31; otherwise the phase keeps the sum. The long-run step rate is therefore P/2^31 per tick.
- R6: With a prescaler of 0x80000000, every selected tick produces exactly one step.
- R7: A prescaler above 0x80000000 is treated as 0x80000000, which gives one step per selected tick and never more.
- R8: Cycles with no selected tick leave the count and the phase unchanged. A prescaler of 0 never produces a step.
- R9: A tick sampled at a clock edge changes `count` at that same edge. `step_pulse` is high in the following cycle if and only if `count` changed at that edge. A register write takes effect for ticks sampled at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| xtal_tick | input | 1 | Crystal-rate tick enable |
| alt_tick | input | 1 | Alternate bus-clock tick enable |
| count | output | 64 | Timer count |
| step_pulse | output | 1 | High for one cycle after each timer step |

## Verification
The bench targets the phase remainder with an irregular prescaler such as 0x12345678 over hundreds of ticks. A design that reset the phase on every carry, or that ran the accumulator one bit too wide, would fall to half rate or drift away from the reference model within a few steps. The saturation case uses 0xFFFFFFFF. Without the clamp, the wrapping add would produce erratic skipped steps. Source-select and step-size changes are made while ticks are arriving on both inputs. A design that read the wrong tick, or used the new step size one edge too early, would disagree with the model in the first cycle after the change. Writes to an unmapped offset are followed by readback of both registers, which exposes any address aliasing.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    localparam int CTRL_OFS  = 'h000;
    localparam int PRESC_OFS = 'h008;
    localparam int SRC_BIT   = 8;
    localparam int DBL_BIT   = 9;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] presc;
    } regs_t;
endpackage

// File: rtl/ctg_regs.sv
module ctg_regs
    import ctg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] presc_o
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(PRESC_OFS);
    localparam logic [DATA_W-1:0] PRESC_RST = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] presc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == A_CTRL)  st_d.ctrl  = bus_wdata;
        if (bus_wr && bus_addr == A_PRESC) st_d.presc = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.presc <= PRESC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (bus_addr == A_CTRL)       bus_rdata = st_q.ctrl;
        else if (bus_addr == A_PRESC) bus_rdata = st_q.presc;
        else                          bus_rdata = '0;
    end

    assign ctrl_o  = st_q.ctrl;
    assign presc_o = st_q.presc;

    a_r2_presc_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_PRESC |=> presc_o == $past(bus_wdata));
    a_r2_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr != A_CTRL && bus_addr != A_PRESC
        |=> $stable(ctrl_o) && $stable(presc_o));
endmodule

// File: rtl/ctg_phase.sv
module ctg_phase #(
    parameter int PRESC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [PRESC_W-1:0] presc,
    output logic               adv,
    output logic               step_q_o
);
    localparam int PH_W = PRESC_W - 1;
    localparam logic [PRESC_W-1:0] UNITY = {1'b1, {PH_W{1'b0}}};

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            step;
    } st_t;

    st_t st_d, st_q;
    logic [PRESC_W-1:0] eff;
    logic [PRESC_W-1:0] sum;

    always_comb begin
        eff  = (presc > UNITY) ? UNITY : presc;
        sum  = {1'b0, st_q.phase} + eff;
        adv  = tick && sum[PRESC_W-1];
        st_d = st_q;
        st_d.step = adv;
        if (tick) st_d.phase = sum[PH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_q_o = st_q.step;

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.phase) && !step_q_o);
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        tick && presc >= UNITY |=> step_q_o);
    a_r8_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        presc == '0 |=> !step_q_o);
endmodule

// File: rtl/ctg_counter.sv
module ctg_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             dbl,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) st_d.cnt = st_q.cnt + (dbl ? CNT_W'(2) : CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> count_o == $past(count_o) + ($past(dbl) ? CNT_W'(2) : CNT_W'(1)));
    a_r9_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(count_o));
endmodule

// File: rtl/core_timer_gen.sv
module core_timer_gen
    import ctg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xtal_tick,
    input  logic              alt_tick,
    output logic [CNT_W-1:0]  count,
    output logic              step_pulse
);
    logic [DATA_W-1:0] ctrl_w, presc_w;
    logic              sel_tick, adv_w;

    ctg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_o(ctrl_w), .presc_o(presc_w)
    );

    assign sel_tick = ctrl_w[SRC_BIT] ? alt_tick : xtal_tick;

    ctg_phase #(.PRESC_W(DATA_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(sel_tick), .presc(presc_w),
        .adv(adv_w), .step_q_o(step_pulse)
    );

    ctg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv_w), .dbl(ctrl_w[DBL_BIT]),
        .count_o(count)
    );

    a_r3_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w[SRC_BIT] ? !alt_tick : !xtal_tick) |=> $stable(count) && !step_pulse);
    a_r9_pulse_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> count != $past(count));
endmodule

// File: tb/core_timer_gen_test.sv
module core_timer_gen_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        xtal_tick = 0, alt_tick = 0;
    logic [63:0] count;
    logic        step_pulse;

    int total = 0, bad = 0;
    int cycles = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_ctrl = 0, m_presc = 32'h8000_0000;
    longint unsigned m_phase = 0;
    logic [63:0] m_count = 0;
    bit m_step = 0;

    core_timer_gen uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xtal_tick(xtal_tick),
        .alt_tick(alt_tick), .count(count), .step_pulse(step_pulse)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, compared after every edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ctrl = 0; m_presc = 32'h8000_0000; m_phase = 0; m_count = 0; m_step = 0;
        end else begin
            bit t;
            longint unsigned p, s;
            t = m_ctrl[8] ? alt_tick : xtal_tick;
            p = (m_presc > 32'h8000_0000) ? 64'h8000_0000 : longint'(m_presc);
            m_step = 0;
            if (t) begin
                s = m_phase + p;
                if (s >= 64'h8000_0000) begin
                    m_step = 1;
                    s = s - 64'h8000_0000;
                    m_count = m_count + (m_ctrl[9] ? 64'd2 : 64'd1);
                end
                m_phase = s;
            end
            if (bus_wr && bus_addr == 8'h00) m_ctrl = bus_wdata;
            if (bus_wr && bus_addr == 8'h08) m_presc = bus_wdata;
        end
        #1;
        if (rst_n) begin
            chk(cur_req, count, m_count);
            chk("R9", {63'd0, step_pulse}, {63'd0, m_step});
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(bit x, bit a);
        @(negedge clk);
        bus_wr = 0; xtal_tick = x; alt_tick = a;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; xtal_tick = 0; alt_tick = 0;
    endtask

    task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_wr = 0; bus_addr = a; xtal_tick = 0; alt_tick = 0;
        #1 chk(req, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd("R1", 8'h00, 32'h0);
        rd("R1", 8'h08, 32'h8000_0000);
        #1 chk("R1", count, 64'd0);
        chk("R1", {63'd0, step_pulse}, 64'd0);

        // R6 one-to-one
        cur_req = "R6";
        for (int i = 0; i < 20; i++) drive(1, 0);
        for (int i = 0; i < 10; i++) drive(i % 2 == 0, 0);

        // R5 fractional rates
        cur_req = "R5";
        wr(8'h08, 32'h4000_0000);
        for (int i = 0; i < 60; i++) drive(i % 3 != 0, 1);
        wr(8'h08, 32'h1234_5678);
        for (int i = 0; i < 300; i++) drive(1, 0);
        for (int i = 0; i < 200; i++) drive($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);

        // R7 saturation
        cur_req = "R7";
        wr(8'h08, 32'hFFFF_FFFF);
        for (int i = 0; i < 40; i++) drive(1, 0);
        wr(8'h08, 32'h8000_0001);
        for (int i = 0; i < 20; i++) drive(1, 0);

        // R4 double step, change while ticking
        cur_req = "R4";
        wr(8'h08, 32'h6000_0000);
        wr(8'h00, 32'h0000_0200);
        for (int i = 0; i < 50; i++) drive(1, 1);
        wr(8'h00, 32'h0000_0000);
        for (int i = 0; i < 20; i++) drive(1, 1);

        // R3 source select
        cur_req = "R3";
        wr(8'h00, 32'h0000_0100);
        for (int i = 0; i < 30; i++) drive(1, 0);
        for (int i = 0; i < 30; i++) drive(i % 2 == 1, 1);
        wr(8'h00, 32'h0000_0300);
        for (int i = 0; i < 30; i++) drive($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);

        // R8 hold and zero prescaler
        cur_req = "R8";
        for (int i = 0; i < 20; i++) drive(1, 0);
        wr(8'h08, 32'h0);
        for (int i = 0; i < 40; i++) drive(1, 1);

        // R2 register map
        cur_req = "R2";
        wr(8'h00, 32'hA5A5_5A5A);
        wr(8'h08, 32'h0F0F_1234);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h1111_1111);
        rd("R2", 8'h00, 32'hA5A5_5A5A);
        rd("R2", 8'h08, 32'h0F0F_1234);
        rd("R2", 8'h04, 32'h0);
        rd("R2", 8'h10, 32'h0);
        for (int i = 0; i < 20; i++) drive(1, 1);

        drive(0, 0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule